// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses, in the same cycle a fetch address is presented, whether a conditional branch at that address will be taken. It runs two component predictors side by side. One is a table of 2-bit saturating counters selected directly by the fetch address. The other is a table of the same counters selected by the fetch address XORed with a global record of recent branch directions. A third table of 2-bit counters, selected by the fetch address, learns per entry which component tends to be right. The final guess is the output of the component that this chooser counter favours.

The front end presents `pred_pc` with `pred_valid`. It reads back the final direction, the history value used for the lookup, and the two component guesses. It keeps that snapshot alongside the branch. When the branch resolves, the snapshot comes back on the update port together with the real outcome. The update trains all three tables. If the final guess was wrong, the update also repairs the history register. None of the tables carry tags or valid bits, so branches whose indices collide share counters.

Top module: `tdp_predictor`

## Requirements
- R1: After reset every counter in all three tables holds 01 and the history register is all zeros. As a result, `pred_taken`, `pred_bim` and `pred_gsh` are 0 and `pred_hist` is 0 for any address.
- R2: Counters use 00 for strongly not taken, 01 for weakly not taken, 10 for weakly taken and 11 for strongly taken. A component guess is the counter's upper bit. On each update a counter steps up by one for a taken outcome and down by one for a not-taken outcome, and it holds at 11 and at 00.
- R3: The address-indexed table and the chooser table are both indexed by `pc[12:2]`. Address bits above 12 take no part in the lookup, so two addresses that differ only there read the same entries.
- R4: The history-indexed table is indexed by `pc[12:2] XOR history`, with history bit 0 aligned to `pc[2]`.
- R5: `pred_hist` shows the history before the current prediction. A cycle with `pred_valid` high, and no repair in that cycle, shifts the history left by one and places the final guess in bit 0.
- R6: An update whose `upd_taken` differs from `upd_pred` loads the history with `{upd_hist[9:0], upd_taken}`. This repair takes precedence over a prediction in the same cycle.
- R7: When the chooser counter's upper bit is 1, `pred_taken` equals `pred_gsh`; otherwise it equals `pred_bim`. When both components agree, `pred_taken` is that common value.
- R8: On an update where `upd_bim` and `upd_gsh` differ, the chooser counter steps up if `upd_gsh` equals the outcome and down otherwise. When the two components agree, the chooser counter is left unchanged.
- R9: Every update trains the address-indexed entry at `upd_pc[12:2]` and the history-indexed entry at `upd_pc[12:2] XOR upd_hist` with `upd_taken`.
- R10: A prediction that reads an entry written by an update in the same cycle returns the value held before that update. The new value appears from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | A branch is being predicted this cycle |
| pred_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Final direction guess, 1 = taken |
| pred_hist | output | 11 | History value used for this lookup (snapshot) |
| pred_bim | output | 1 | Guess of the address-indexed component |
| pred_gsh | output | 1 | Guess of the history-indexed component |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| upd_pred | input | 1 | Final guess that was given for it |
| upd_hist | input | 11 | History snapshot returned from prediction |
| upd_bim | input | 1 | Address-indexed guess returned from prediction |
| upd_gsh | input | 1 | History-indexed guess returned from prediction |

## Verification
A counter that steps the wrong way or fails to saturate stays hidden until its entry is read again. It then shows up as a wrong `pred_bim`, `pred_gsh` or `pred_taken` in the very cycle that entry's address is presented, so the bench keeps a full shadow of all three tables and compares every lookup. A fault in the history register is visible on `pred_hist` one cycle after the faulty shift or repair. From there it shifts the history-indexed lookups of every later branch, so it spreads quickly into `pred_gsh` mismatches. Directed sequences pin down saturation, aliasing above bit 12, same-cycle read-before-write and the precedence of repair over speculation with literal expected values.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_WT  = 2'b10;
    localparam ctr_t CTR_ST  = 2'b11;

    // Saturating up/down step of a 2-bit confidence counter.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t res;
        if (up) begin
            res = (cur == CTR_ST) ? CTR_ST : ctr_t'(cur + 2'd1);
        end else begin
            res = (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
        end
        return res;
    endfunction

endpackage

// File: rtl/tdp_ctr_table.sv
module tdp_ctr_table
    import tdp_pkg::*;
#(
    parameter int   IDX_W   = 11,
    parameter ctr_t RST_VAL = CTR_WNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_dir
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t mem_q [DEPTH];
    ctr_t wr_val_d;

    // Read is combinational from the registered array: a same-cycle
    // write is only visible after the clock edge.
    assign rd_ctr = mem_q[rd_idx];

    always_comb begin
        wr_val_d = ctr_step(mem_q[wr_idx], wr_dir);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= RST_VAL;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_val_d;
        end
    end

    // R2: a trained entry moves only in the outcome's direction.
    p_step_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (( $past(wr_dir) && (mem_q[$past(wr_idx)] >= $past(mem_q[wr_idx]))) ||
                   (!$past(wr_dir) && (mem_q[$past(wr_idx)] <= $past(mem_q[wr_idx])))));

    // R2: saturation at the strong-taken end.
    p_sat_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dir && (mem_q[wr_idx] == CTR_ST)) |=> (mem_q[$past(wr_idx)] == CTR_ST));

    // R2: saturation at the strong-not-taken end.
    p_sat_bot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dir && (mem_q[wr_idx] == CTR_SNT)) |=> (mem_q[$past(wr_idx)] == CTR_SNT));

endmodule

// File: rtl/tdp_history.sv
module tdp_history #(
    parameter int HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_hist,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist_q
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } hist_state_t;

    hist_state_t st_d;
    hist_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (fix_en) begin
            st_d.hist = {fix_hist[HIST_W-2:0], fix_bit};
        end else if (spec_en) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], spec_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_q = st_q.hist;

    // R5: speculative shift places the guess in bit 0.
    p_spec_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_en && !fix_en) |=> ((hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])) &&
                                 (hist_q[0] == $past(spec_bit))));

    // R6: repair rebuilds history from the snapshot and real outcome.
    p_repair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> ((hist_q[HIST_W-1:1] == $past(fix_hist[HIST_W-2:0])) &&
                    (hist_q[0] == $past(fix_bit))));

    // R5: history holds when nothing is predicted or repaired.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_en && !fix_en) |=> (hist_q == $past(hist_q)));

endmodule

// File: rtl/tdp_predictor.sv
module tdp_predictor
    import tdp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 11,
    parameter int HIST_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pred_valid,
    input  logic [PC_W-1:0]   pred_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_hist,
    output logic              pred_bim,
    output logic              pred_gsh,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic              upd_pred,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_bim,
    input  logic              upd_gsh
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + IDX_W - 1;

    logic [HIST_W-1:0] hist_q;
    logic [IDX_W-1:0]  pred_idx;
    logic [IDX_W-1:0]  upd_idx;
    logic [IDX_W-1:0]  pred_hx;
    logic [IDX_W-1:0]  upd_hx;
    logic [IDX_W-1:0]  pred_gidx;
    logic [IDX_W-1:0]  upd_gidx;
    ctr_t              bim_ctr;
    ctr_t              gsh_ctr;
    ctr_t              meta_ctr;
    logic              meta_wr;
    logic              meta_dir;
    logic              repair;
    logic              final_bit;

    assign pred_idx = pred_pc[IDX_HI:IDX_LO];
    assign upd_idx  = upd_pc[IDX_HI:IDX_LO];

    // History narrower than the index is zero-extended before the XOR.
    generate
        if (HIST_W == IDX_W) begin : g_hx_full
            assign pred_hx = hist_q;
            assign upd_hx  = upd_hist;
        end else begin : g_hx_pad
            assign pred_hx = {{(IDX_W - HIST_W){1'b0}}, hist_q};
            assign upd_hx  = {{(IDX_W - HIST_W){1'b0}}, upd_hist};
        end
    endgenerate

    assign pred_gidx = pred_idx ^ pred_hx;
    assign upd_gidx  = upd_idx ^ upd_hx;

    tdp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_bim (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_idx),
        .rd_ctr (bim_ctr),
        .wr_en  (upd_valid),
        .wr_idx (upd_idx),
        .wr_dir (upd_taken)
    );

    tdp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_gsh (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_gidx),
        .rd_ctr (gsh_ctr),
        .wr_en  (upd_valid),
        .wr_idx (upd_gidx),
        .wr_dir (upd_taken)
    );

    // Chooser: upper bit 1 selects the history-indexed side.
    // Trained only when the components disagreed.
    assign meta_wr  = upd_valid && (upd_bim != upd_gsh);
    assign meta_dir = (upd_gsh == upd_taken);

    tdp_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_meta (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (pred_idx),
        .rd_ctr (meta_ctr),
        .wr_en  (meta_wr),
        .wr_idx (upd_idx),
        .wr_dir (meta_dir)
    );

    always_comb begin
        final_bit = meta_ctr[1] ? gsh_ctr[1] : bim_ctr[1];
    end

    assign repair = upd_valid && (upd_taken != upd_pred);

    tdp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (pred_valid),
        .spec_bit (final_bit),
        .fix_en   (repair),
        .fix_hist (upd_hist),
        .fix_bit  (upd_taken),
        .hist_q   (hist_q)
    );

    assign pred_taken = final_bit;
    assign pred_hist  = hist_q;
    assign pred_bim   = bim_ctr[1];
    assign pred_gsh   = gsh_ctr[1];

    // R7: when both components agree the final guess follows them.
    p_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && (pred_bim == pred_gsh)) |-> (pred_taken == pred_bim));

    // R6: a repair overrides a same-cycle speculative shift.
    p_repair_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (repair && pred_valid) |=> (pred_hist[0] == $past(upd_taken)));

endmodule

// File: tb/tdp_predictor_bench.sv
`timescale 1ns/1ps
module tdp_predictor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic [10:0] pred_hist;
    logic        pred_bim;
    logic        pred_gsh;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        upd_pred = 1'b0;
    logic [10:0] upd_hist = '0;
    logic        upd_bim = 1'b0;
    logic        upd_gsh = 1'b0;

    always #2.5 clk = ~clk;

    tdp_predictor u_tdp_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_valid (pred_valid),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .pred_hist  (pred_hist),
        .pred_bim   (pred_bim),
        .pred_gsh   (pred_gsh),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken),
        .upd_pred   (upd_pred),
        .upd_hist   (upd_hist),
        .upd_bim    (upd_bim),
        .upd_gsh    (upd_gsh)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Shadow model of the three tables and history.
    logic [1:0]  bim_m  [2048];
    logic [1:0]  gsh_m  [2048];
    logic [1:0]  meta_m [2048];
    logic [10:0] hist_m;

    // Last observed snapshot.
    logic        o_t, o_b, o_g;
    logic [10:0] o_h;

    function automatic logic [1:0] m_step(input logic [1:0] c, input logic up);
        if (up) return (c == 2'b11) ? 2'b11 : c + 2'd1;
        return (c == 2'b00) ? 2'b00 : c - 2'd1;
    endfunction

    function automatic logic [10:0] m_idx(input logic [31:0] pc);
        return pc[12:2];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2048; i++) begin
            bim_m[i] = 2'b01; gsh_m[i] = 2'b01; meta_m[i] = 2'b01;
        end
        hist_m = '0;
    endtask

    // One cycle: drive at the falling edge, compare the combinational
    // snapshot 1 ns later, then advance the model to the next edge.
    task automatic step(input logic pv, input logic [31:0] ppc,
                        input logic uv, input logic [31:0] upc, input logic ut,
                        input logic up, input logic [10:0] uh, input logic ub,
                        input logic ug, input string tag);
        logic eb, eg, em, et;
        logic [10:0] bi, gi, ui, ugi;
        @(negedge clk);
        pred_valid = pv; pred_pc = ppc;
        upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_pred = up;
        upd_hist = uh; upd_bim = ub; upd_gsh = ug;
        #1;
        bi = m_idx(ppc);
        gi = bi ^ hist_m;
        eb = bim_m[bi][1];
        eg = gsh_m[gi][1];
        em = meta_m[bi][1];
        et = em ? eg : eb;
        check({pred_taken, pred_bim, pred_gsh, pred_hist} == {et, eb, eg, hist_m},
              tag, {18'd0, pred_taken, pred_bim, pred_gsh, pred_hist},
              {18'd0, et, eb, eg, hist_m});
        o_t = pred_taken; o_b = pred_bim; o_g = pred_gsh; o_h = pred_hist;
        if (uv) begin
            ui  = m_idx(upc);
            ugi = ui ^ uh;
            bim_m[ui]  = m_step(bim_m[ui], ut);
            gsh_m[ugi] = m_step(gsh_m[ugi], ut);
            if (ub != ug) meta_m[ui] = m_step(meta_m[ui], ug == ut);
        end
        if (uv && (ut != up)) hist_m = {uh[9:0], ut};
        else if (pv) hist_m = {hist_m[9:0], et};
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, tag);
    endtask

    // Outstanding predictions awaiting resolution.
    logic [31:0] q_pc [8];
    logic [10:0] q_h  [8];
    logic        q_b  [8];
    logic        q_g  [8];
    logic        q_p  [8];
    int          q_n = 0;

    initial begin : wdog
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a;
        logic        h0;
        void'($urandom(32'd20131));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every output.
        idle("R1 reset outputs");
        check({pred_taken, pred_bim, pred_gsh} == 3'b000, "R1 reset guesses",
              {29'd0, pred_taken, pred_bim, pred_gsh}, 32'd0);
        check(pred_hist == 11'd0, "R1 reset history", {21'd0, pred_hist}, 32'd0);

        // R2 R9: train address A taken four times (hist snapshot 0, guesses 0).
        a = 32'h0000_0100;
        for (int i = 0; i < 4; i++)
            step(1'b0, a, 1'b1, a, 1'b1, 1'b1, '0, 1'b0, 1'b0, "R2 R9 train taken");
        step(1'b0, a, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 saturated read");
        check(pred_bim == 1'b1, "R2 strong taken", {31'd0, pred_bim}, 32'd1);
        // One not-taken outcome: 11 -> 10, still taken (hysteresis).
        step(1'b0, a, 1'b1, a, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 step down");
        step(1'b0, a, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 weak taken read");
        check(pred_bim == 1'b1, "R2 weak taken holds", {31'd0, pred_bim}, 32'd1);
        step(1'b0, a, 1'b1, a, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 step down again");
        step(1'b0, a, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 weak not taken read");
        check(pred_bim == 1'b0, "R2 weak not taken", {31'd0, pred_bim}, 32'd0);
        // Saturate low: three not-taken outcomes from 01.
        for (int i = 0; i < 3; i++)
            step(1'b0, a, 1'b1, a, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 saturate low");
        step(1'b0, a, 1'b1, a, 1'b1, 1'b1, '0, 1'b0, 1'b0, "R2 one up from floor");
        step(1'b0, a, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R2 floor read");
        check(pred_bim == 1'b0, "R2 floor 00->01 stays not taken", {31'd0, pred_bim}, 32'd0);

        // R10: same-cycle update to 10 is not seen by the read.
        step(1'b0, a, 1'b1, a, 1'b1, 1'b1, '0, 1'b0, 1'b0, "R10 collide");
        check(pred_bim == 1'b0, "R10 old value read", {31'd0, pred_bim}, 32'd0);
        step(1'b0, a, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R10 next cycle");
        check(pred_bim == 1'b1, "R10 new value next cycle", {31'd0, pred_bim}, 32'd1);

        // R3: an address differing only above bit 12 aliases.
        step(1'b0, a | 32'h0010_0000, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R3 alias");
        check(pred_bim == 1'b1, "R3 alias shares entry", {31'd0, pred_bim}, 32'd1);

        // R6: repair wins over a same-cycle prediction.
        step(1'b1, 32'h0000_0200, 1'b1, 32'h0000_0300, 1'b1, 1'b0, 11'h155,
             1'b0, 1'b0, "R6 repair with predict");
        idle("R6 repaired history");
        check(pred_hist == 11'h2AB, "R6 repaired history", {21'd0, pred_hist}, 32'h2AB);

        // R5: speculative shift with the observed guess.
        step(1'b1, 32'h0000_0104, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R5 speculate");
        h0 = o_t;
        idle("R5 shifted history");
        check(pred_hist == {11'h2AB << 1} + {10'd0, h0}, "R5 speculative shift",
              {21'd0, pred_hist}, {21'd0, 11'(11'h2AB << 1) | {10'd0, h0}});

        // R4: history-indexed entry depends on the XOR with history.
        // Train entry index 1 via upd_pc idx 0 with history 1, then read
        // it through pc idx 3 while history is 2 (3 ^ 2 = 1).
        for (int i = 0; i < 2; i++)
            step(1'b0, '0, 1'b1, 32'h0000_0000, 1'b1, 1'b1, 11'h001, 1'b0, 1'b0,
                 "R4 R9 train xor entry");
        step(1'b0, '0, 1'b1, 32'h0000_4000, 1'b0, 1'b1, 11'h001, 1'b0, 1'b0,
             "R6 force history 2");
        step(1'b0, 32'h0000_000C, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, "R4 xor read");
        check(pred_hist == 11'h002 && pred_gsh == 1'b1, "R4 xor index",
              {20'd0, pred_gsh, pred_hist}, {20'd0, 1'b1, 11'h002});

        // Random traffic; R7 R8 covered by the shadow comparison.
        for (int c = 0; c < 4000; c++) begin
            logic pv, uv, ut;
            logic [31:0] ppc, upc;
            logic [10:0] uh;
            logic ub, ug, up;
            pv  = ($urandom % 4) != 0;
            ppc = {$urandom % 4, 15'd0, 4'd0, 3'(($urandom % 8)), 2'b00};
            uv  = (q_n > 0) && (($urandom % 3) != 0);
            upc = '0; uh = '0; ub = 0; ug = 0; up = 0; ut = 0;
            if (uv) begin
                upc = q_pc[0]; uh = q_h[0]; ub = q_b[0]; ug = q_g[0]; up = q_p[0];
                ut  = upc[3] ? (($urandom % 8) != 0) : (($urandom % 8) == 0);
                for (int k = 0; k < 7; k++) begin
                    q_pc[k] = q_pc[k+1]; q_h[k] = q_h[k+1];
                    q_b[k] = q_b[k+1]; q_g[k] = q_g[k+1]; q_p[k] = q_p[k+1];
                end
                q_n--;
            end
            if (pv && q_n == 8) pv = 1'b0;
            step(pv, ppc, uv, upc, ut, up, uh, ub, ug, "R7 R8 R9 random");
            if (pv) begin
                q_pc[q_n] = ppc; q_h[q_n] = o_h; q_b[q_n] = o_b;
                q_g[q_n] = o_g; q_p[q_n] = o_t;
                q_n++;
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule